// File: doc/BRIEF.md
# Time-of-Year Calendar Counter

This block keeps calendar time from a slow tick pulse that marks each cycle of a 32.768 kHz oscillator. The tick is a one-cycle enable in the system clock domain. A programmable prescaler turns every `trim+1` ticks into one second step. A carry chain then advances seconds, minutes, hours, day of month, month and a full 32-bit year. Software reads and writes the block through a small word-addressed register port.

Time and trim writes are posted. The written value is staged, and the control word shows a busy flag. The staged value is applied after a fixed number of ticks, and the flag then clears. A write to a register group whose busy flag is set is dropped. The read registers always return the live count, never the staged value.

Top module: `toy_clock`

## Requirements
- R1: After reset the packed time word reads 0x04200000 (month 1, day 1, all else 0), the year reads 0, the trim reads 0 and the control word reads 0x00000100.
- R2: Register addresses are: 0 trim (read/write), 1 packed time write, 2 year write, 3 packed time read, 4 year read, 5 control/status. The packed word puts seconds in [9:4], minutes in [15:10], hours in [20:16], day in [25:21] and month in [31:26]. Bits [3:0] read 0.
- R3: One second step occurs every trim+1 ticks.
- R4: Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and carry into the day.
- R5: The day rolls to 1 after the month's last day. Months 4, 6, 9 and 11 have 30 days, February has 29 days in a leap year (divisible by 4 and not by 100, or divisible by 400) and 28 otherwise, and all other months have 31. Month 12 rolls to 1 and increments the year.
- R6: A write to address 1 or 2 sets control bit 0. The bit stays set for SYNC_TICKS ticks. On the last of those ticks the staged value replaces the live one and the bit clears. While the bit is set, reads return the live, still-counting value.
- R7: A write to address 1 or 2 while control bit 0 is set is ignored.
- R8: A write to address 0 sets control bit 4 for SYNC_TICKS ticks, after which the new trim applies. A trim write while bit 4 is set is ignored.
- R9: Control bit 8 (counter enabled) reads 1. Control bit 5 (oscillator running) is set from the first tick after reset onward.
- R10: On the tick that applies a staged packed time, the staged value wins over that tick's second step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per oscillator period |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed register (combinational) |

## Verification
The bench builds the block with SYNC_TICKS at 3 and drives the tick input itself, one pulse per task call. Trim resets to 0, so every tick is a second step until trim is changed. Together, these let the bench reach the 59-second, 59-minute and 23-hour carries, the month-length and leap-year rules (2023, 2024 and 2100), and the December-to-January year carry within a handful of ticks. The trim case loads a ratio of 3 and confirms that the seconds value stays put for two ticks and then steps on the third.

// File: rtl/toy_pkg.sv
package toy_pkg;
  localparam int DATA_W = 32;

  localparam logic [2:0] A_TRIM  = 3'd0;
  localparam logic [2:0] A_TIMEW = 3'd1;
  localparam logic [2:0] A_YEARW = 3'd2;
  localparam logic [2:0] A_TIMER = 3'd3;
  localparam logic [2:0] A_YEARR = 3'd4;
  localparam logic [2:0] A_CTRL  = 3'd5;

  typedef struct packed {
    logic              loadTime;
    logic              loadYear;
    logic              loadTrim;
    logic [DATA_W-1:0] timeData;
    logic [DATA_W-1:0] yearData;
    logic [DATA_W-1:0] trimData;
  } toyStrobe_t;

  function automatic logic isLeap(input logic [DATA_W-1:0] y);
    return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
  endfunction

  function automatic logic [4:0] monthDays(input logic [5:0] m, input logic [DATA_W-1:0] y);
    case (m)
      6'd2:                   return isLeap(y) ? 5'd29 : 5'd28;
      6'd4, 6'd6, 6'd9, 6'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/toy_ctrl.sv
module toy_ctrl
  import toy_pkg::*;
#(
  parameter int SYNC_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic              timeBusy,
  output logic              trimBusy,
  output logic              oscSeen,
  output toyStrobe_t        str
);
  localparam int CNT_W = $clog2(SYNC_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SYNC_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0]  timeCnt, trimCnt;
  logic              pendTime, pendYear;
  logic [DATA_W-1:0] stTime, stYear, stTrim;

  wire timeWr = regWrEn && (regAddr == A_TIMEW || regAddr == A_YEARW);
  wire trimWr = regWrEn && (regAddr == A_TRIM);
  wire timeDone = timeBusy && tick && (timeCnt == CNT_LAST);
  wire trimDone = trimBusy && tick && (trimCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeBusy <= 1'b0;
      trimBusy <= 1'b0;
      oscSeen  <= 1'b0;
      timeCnt  <= '0;
      trimCnt  <= '0;
      pendTime <= 1'b0;
      pendYear <= 1'b0;
      stTime   <= '0;
      stYear   <= '0;
      stTrim   <= '0;
    end else begin
      if (tick) oscSeen <= 1'b1;

      if (timeBusy) begin
        if (timeDone) timeBusy <= 1'b0;
        else if (tick) timeCnt <= timeCnt - 1'b1;
      end else if (timeWr) begin
        timeBusy <= 1'b1;
        timeCnt  <= CNT_INIT;
        pendTime <= (regAddr == A_TIMEW);
        pendYear <= (regAddr == A_YEARW);
        if (regAddr == A_TIMEW) stTime <= regWrData;
        else stYear <= regWrData;
      end

      if (trimBusy) begin
        if (trimDone) trimBusy <= 1'b0;
        else if (tick) trimCnt <= trimCnt - 1'b1;
      end else if (trimWr) begin
        trimBusy <= 1'b1;
        trimCnt  <= CNT_INIT;
        stTrim   <= regWrData;
      end
    end
  end

  always_comb begin
    str.loadTime = timeDone && pendTime;
    str.loadYear = timeDone && pendYear;
    str.loadTrim = trimDone;
    str.timeData = stTime;
    str.yearData = stYear;
    str.trimData = stTrim;
  end

  // R6: the busy flag only rises after a time-register write
  a_r6_busy_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeBusy) |-> $past(regWrEn));
  // R6: a staged load is only issued while the flag is set
  a_r6_load_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    (str.loadTime || str.loadYear) |-> timeBusy);
  // R7: a write during busy leaves the staged value untouched
  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (timeBusy && timeWr) |=> ($stable(stTime) && $stable(stYear)));
  // R8: a trim write during busy leaves the staged trim untouched
  a_r8_trim_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (trimBusy && trimWr) |=> $stable(stTrim));
endmodule

// File: rtl/toy_datapath.sv
module toy_datapath
  import toy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  toyStrobe_t        str,
  output logic [DATA_W-1:0] timeWord,
  output logic [DATA_W-1:0] yearVal,
  output logic [DATA_W-1:0] trimVal
);
  logic [5:0]        sec, min, mon;
  logic [4:0]        hr, day;
  logic [DATA_W-1:0] pre;

  wire stepSec = tick && (pre >= trimVal);
  wire secWrap = sec >= 6'd59;
  wire minWrap = secWrap && (min >= 6'd59);
  wire hrWrap  = minWrap && (hr >= 5'd23);
  wire dayWrap = hrWrap && (day >= monthDays(mon, yearVal));
  wire monWrap = dayWrap && (mon >= 6'd12);

  assign timeWord = {mon, day, hr, min, sec, 4'b0000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec <= '0; min <= '0; hr <= '0;
      day <= 5'd1; mon <= 6'd1;
      yearVal <= '0;
      trimVal <= '0;
      pre <= '0;
    end else begin
      if (tick) pre <= stepSec ? '0 : pre + 1'b1;
      if (str.loadTrim) trimVal <= str.trimData;

      if (str.loadTime) begin
        {mon, day, hr, min, sec} <= str.timeData[31:4];
      end else if (stepSec) begin
        sec <= secWrap ? 6'd0 : sec + 1'b1;
        if (secWrap) min <= minWrap ? 6'd0 : min + 1'b1;
        if (minWrap) hr <= hrWrap ? 5'd0 : hr + 1'b1;
        if (hrWrap) day <= dayWrap ? 5'd1 : day + 1'b1;
        if (dayWrap) mon <= monWrap ? 6'd1 : mon + 1'b1;
      end

      if (str.loadYear) yearVal <= str.yearData;
      else if (stepSec && monWrap && !str.loadTime) yearVal <= yearVal + 1'b1;
    end
  end

  // R3: after any tick that did not load trim, the prescaler stays within range
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tick) && !$past(str.loadTrim)) |-> (pre <= trimVal));
  // R4: a second step at 59 returns seconds to 0
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stepSec && !str.loadTime && sec == 6'd59) |=> (sec == 6'd0));
  // R10: a staged load lands exactly, even on a stepping tick
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    str.loadTime |=> (timeWord[31:4] == $past(str.timeData[31:4])));
  // R5: day of month never reads 0
  a_r5_day_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    $past(stepSec) && !$past(str.loadTime) && $past(day) != 5'd0 |-> day != 5'd0);
endmodule

// File: rtl/toy_clock.sv
module toy_clock
  import toy_pkg::*;
#(
  parameter int SYNC_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);
  toyStrobe_t        str;
  logic              timeBusy, trimBusy, oscSeen;
  logic [DATA_W-1:0] timeWord, yearVal, trimVal;

  toy_ctrl #(.SYNC_TICKS(SYNC_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .timeBusy(timeBusy), .trimBusy(trimBusy), .oscSeen(oscSeen), .str(str)
  );

  toy_datapath uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .str(str),
    .timeWord(timeWord), .yearVal(yearVal), .trimVal(trimVal)
  );

  always_comb begin
    case (regAddr)
      A_TRIM:  regRdData = trimVal;
      A_TIMER: regRdData = timeWord;
      A_YEARR: regRdData = yearVal;
      A_CTRL:  regRdData = {23'b0, 1'b1, 2'b00, oscSeen, trimBusy, 3'b000, timeBusy};
      default: regRdData = '0;
    endcase
  end

  // R9: the oscillator-running bit never drops once set
  a_r9_osc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(oscSeen) |-> oscSeen);
endmodule

// File: tb/sim_toy_clock.sv
module sim_toy_clock;
  localparam int PERIOD = 10;
  localparam int SYNC = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int nApplied = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  toy_clock #(.SYNC_TICKS(SYNC)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pk(int s, int mi, int h, int d, int mo);
    return (32'(mo) << 26) | (32'(d) << 21) | (32'(h) << 16) | (32'(mi) << 10) | (32'(s) << 4);
  endfunction

  // monitor: pops expected items and compares them with the read port
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      nApplied++;
      if (regRdData !== it.exp) begin
        nFail++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, regRdData, it.exp);
      end
    end
  end

  task automatic expectRd(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    regAddr = a;
    q.push_back('{addr: a, exp: e, tag: tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic doTick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
    end
  endtask

  // set year then packed time; each commit takes SYNC ticks, each a second step while trim is 0
  task automatic setAll(input logic [31:0] y, input logic [31:0] t);
    wr(3'd2, y); doTick(SYNC);
    wr(3'd1, t); doTick(SYNC);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    expectRd(3'd3, 32'h04200000, "R1 time");
    expectRd(3'd4, 32'd0, "R1 year");
    expectRd(3'd0, 32'd0, "R1 trim");
    expectRd(3'd5, 32'h00000100, "R1 ctrl");

    // R9 oscillator bit after first tick; R3 trim 0 -> one step per tick
    doTick(1);
    expectRd(3'd5, 32'h00000120, "R9 osc bit");
    expectRd(3'd3, pk(1, 0, 0, 1, 1), "R3 step per tick");

    // R6 busy set, live reads; R7 write during busy dropped
    wr(3'd2, 32'd2023);
    expectRd(3'd5, 32'h00000121, "R6 busy set");
    wr(3'd1, pk(30, 30, 5, 5, 5));
    doTick(1);
    expectRd(3'd3, pk(2, 0, 0, 1, 1), "R6 live read while busy");
    expectRd(3'd4, 32'd0, "R6 year not yet applied");
    doTick(2);
    expectRd(3'd5, 32'h00000120, "R6 busy cleared");
    expectRd(3'd4, 32'd2023, "R6 year applied");
    expectRd(3'd3, pk(4, 0, 0, 1, 1), "R7 ignored time write");

    // R10 load wins, R2 layout readback
    wr(3'd1, pk(58, 59, 23, 28, 2));
    doTick(SYNC);
    expectRd(3'd3, pk(58, 59, 23, 28, 2), "R10 load wins / R2 layout");
    doTick(1);
    expectRd(3'd3, pk(59, 59, 23, 28, 2), "R4 sec count");
    doTick(1);
    expectRd(3'd3, pk(0, 0, 0, 1, 3), "R5 Feb 2023 has 28 days, R4 carries");

    // R5 leap year
    setAll(32'd2024, pk(59, 59, 23, 28, 2));
    doTick(1);
    expectRd(3'd3, pk(0, 0, 0, 29, 2), "R5 Feb 29 in 2024");
    wr(3'd1, pk(59, 59, 23, 29, 2)); doTick(SYNC);
    doTick(1);
    expectRd(3'd3, pk(0, 0, 0, 1, 3), "R5 leap Feb end");

    // R5 thirty-day month
    wr(3'd1, pk(59, 59, 23, 30, 4)); doTick(SYNC);
    doTick(1);
    expectRd(3'd3, pk(0, 0, 0, 1, 5), "R5 Apr 30 rollover");

    // R5 year carry
    wr(3'd1, pk(59, 59, 23, 31, 12)); doTick(SYNC);
    doTick(1);
    expectRd(3'd3, pk(0, 0, 0, 1, 1), "R5 Dec 31 rollover");
    expectRd(3'd4, 32'd2025, "R5 year increment");

    // R5 century non-leap
    setAll(32'd2100, pk(59, 59, 23, 28, 2));
    doTick(1);
    expectRd(3'd3, pk(0, 0, 0, 1, 3), "R5 2100 not leap");

    // R8 trim write, busy, ignore second write, ratio
    wr(3'd0, 32'd2);
    expectRd(3'd5, 32'h00000130, "R8 trim busy");
    wr(3'd0, 32'd7);
    doTick(SYNC);
    expectRd(3'd0, 32'd2, "R8 trim applied, second write ignored");
    expectRd(3'd5, 32'h00000120, "R8 trim busy cleared");
    expectRd(3'd3, pk(3, 0, 0, 1, 3), "R3 pre-trim steps");
    doTick(2);
    expectRd(3'd3, pk(3, 0, 0, 1, 3), "R3 no step before trim+1 ticks");
    doTick(1);
    expectRd(3'd3, pk(4, 0, 0, 1, 3), "R3 step on third tick");

    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
    $finish;
  end
endmodule